// File: doc/BRIEF.md
# Partial Store Lane Aligner

This combinational unit sits between the execute stage of a 32-bit load/store core and a data memory that is always addressed at 4-byte boundaries and takes a write enable for each byte. It receives the store instruction, the effective address as computed (low two bits intact), the source register value and the memory write-enable control of the instruction. It returns a data word with the store value moved into the byte lanes that the address picks, and a 4-bit byte mask telling the memory which lanes to update.

The width of the store comes from the instruction's funct3 field. Byte stores may use any offset. Halfword stores must sit on an even offset, and word stores on offset zero. Any other placement, and any funct3 code that is not a store width, is reported on a misalignment flag and suppresses every byte write. Instructions that are not stores never write and never raise the flag.

Top module: `store_lane_aligner`

## Requirements
- R1: Bit i of `lane_mask` enables byte i of `lane_data` (bits 8i+7..8i), and 0 means no write. A byte store (funct3 000) copies `src_value[7:0]` into lane `eff_addr[1:0]` and sets the mask to 4'b0001 shifted left by `eff_addr[1:0]`.
- R2: A halfword store (funct3 001) at offset 2'b00 puts `src_value[15:0]` in `lane_data[15:0]` with mask 4'b0011. At offset 2'b10 it puts the value in `lane_data[31:16]` with mask 4'b1100.
- R3: A word store (funct3 010) at offset 2'b00 passes `src_value` through unchanged with mask 4'b1111.
- R4: No sign extension takes place. Only the low 8 or 16 bits of `src_value` feed a byte or halfword store, every lane outside the placed value is zero, and `lane_data` is zero for any funct3 other than 000, 001 or 010.
- R5: When `mem_wr_en` is 0, `lane_mask` is 4'b0000 whatever the instruction is.
- R6: funct3 is read from `store_instr[14:12]` and the opcode from `store_instr[6:0]`. The other instruction bits have no effect on any output.
- R7: For the store opcode, `misaligned` is 1 in these cases: a halfword at offset 01 or 11, a word at a non-zero offset, or funct3 not in {000, 001, 010}. When it is 1, `lane_mask` is 4'b0000. The flag does not depend on `mem_wr_en`.
- R8: When `store_instr[6:0]` is not 7'b0100011, `lane_mask` is 4'b0000 and `misaligned` is 0.
- R9: Only `eff_addr[1:0]` affects the outputs. The upper address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| store_instr | input | 32 | Instruction in execution; opcode in [6:0], width code in [14:12] |
| eff_addr | input | 32 | Effective address, low bits not cleared |
| src_value | input | 32 | Register value to be stored |
| mem_wr_en | input | 1 | Memory write enable from control |
| lane_data | output | 32 | Store value moved into its byte lanes |
| lane_mask | output | 4 | Per-byte write enable for the memory |
| misaligned | output | 1 | Store width/offset combination not allowed |

## Verification
Directed cases walk every width over all four offsets, with a register value whose bytes are all distinct and whose top bits are set in every byte. A wrong lane, a swapped half or a stray sign extension therefore shows up as a different byte. Separate vectors flip only the write enable, only the opcode, only the unused instruction bits or only the upper address bits, so gating faults are told apart from placement faults. A seeded random stream then mixes opcodes, all eight funct3 codes and all offsets against a table-driven reference.

// File: rtl/store_lane_pkg.sv
package store_lane_pkg;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned INSTR_W  = 32;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned OFF_W   = $clog2(LANES);
  localparam logic [6:0]  OPC_STORE = 7'b0100011;

  // encoding: log2 of the number of bytes, NONE for unknown widths
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } st_size_e;
endpackage

// File: rtl/store_decode.sv
module store_decode
  import store_lane_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic               is_store_o,
  output st_size_e           size_o
);
  logic [2:0] funct3;

  assign funct3     = instr_i[14:12];
  assign is_store_o = (instr_i[6:0] == OPC_STORE);

  always_comb begin
    unique case (funct3)
      3'b000:  size_o = SZ_BYTE;
      3'b001:  size_o = SZ_HALF;
      3'b010:  size_o = SZ_WORD;
      default: size_o = SZ_NONE;
    endcase
  end
endmodule

// File: rtl/store_align_check.sv
module store_align_check
  import store_lane_pkg::*;
(
  input  st_size_e         size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             ok_o
);
  logic [OFF_W-1:0] low_bits;

  // natural alignment: offset must be a multiple of the access size
  always_comb begin
    low_bits = '0;
    for (int b = 0; b < OFF_W; b++) begin
      if (b < int'(size_i)) low_bits[b] = 1'b1;
    end
    ok_o = (size_i != SZ_NONE) && ((off_i & low_bits) == '0);
  end

  always_comb begin
    if (ok_o && size_i == SZ_WORD) begin
      assert_word_at_zero_R3: assert (off_i == '0);
    end
    if (size_i == SZ_NONE) begin
      assert_unknown_rejected_R7: assert (!ok_o);
    end
  end
endmodule

// File: rtl/store_lane_place.sv
module store_lane_place
  import store_lane_pkg::*;
(
  input  st_size_e         size_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [DATA_W-1:0] value_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  span_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    int rel;
    int nbytes;
    always_comb begin
      rel    = g - int'(off_i);
      nbytes = 1 << int'(size_i);
      span_o[g] = 1'b0;
      data_o[8*g +: 8] = 8'h00;
      if (size_i != SZ_NONE && rel >= 0 && rel < nbytes) begin
        span_o[g] = 1'b1;
        data_o[8*g +: 8] = value_i[8*rel +: 8];
      end
    end
  end

  always_comb begin
    if (size_i == SZ_NONE) begin
      assert_unknown_zero_R4: assert (data_o == '0 && span_o == '0);
    end
  end
endmodule

// File: rtl/store_lane_aligner.sv
module store_lane_aligner
  import store_lane_pkg::*;
(
  input  logic [31:0] store_instr,
  input  logic [31:0] eff_addr,
  input  logic [31:0] src_value,
  input  logic        mem_wr_en,
  output logic [31:0] lane_data,
  output logic [3:0]  lane_mask,
  output logic        misaligned
);
  logic             is_store;
  st_size_e         size;
  logic             align_ok;
  logic [OFF_W-1:0] offset;
  logic [LANES-1:0] span;
  logic [DATA_W-1:0] lane_bits;

  assign offset = eff_addr[OFF_W-1:0];

  store_decode i_decode (
    .instr_i    (store_instr),
    .is_store_o (is_store),
    .size_o     (size)
  );

  store_align_check i_align (
    .size_i (size),
    .off_i  (offset),
    .ok_o   (align_ok)
  );

  store_lane_place i_place (
    .size_i  (size),
    .off_i   (offset),
    .value_i (src_value),
    .data_o  (lane_data),
    .span_o  (span)
  );

  assign lane_mask  = (is_store && mem_wr_en && align_ok) ? span : '0;
  assign misaligned = is_store && !align_ok;

  always_comb begin
    for (int l = 0; l < LANES; l++) lane_bits[8*l +: 8] = {8{lane_mask[l]}};
  end

  always_comb begin
    if (!mem_wr_en) begin
      assert_mask_gated_R5: assert (lane_mask == 4'b0000);
    end
    if (misaligned) begin
      assert_misalign_blocks_R7: assert (lane_mask == 4'b0000);
    end
    if (store_instr[6:0] != OPC_STORE) begin
      assert_nonstore_quiet_R8: assert (lane_mask == 4'b0000 && !misaligned);
    end
    assert_mask_shape_R1: assert (lane_mask inside {4'b0000, 4'b0001, 4'b0010,
      4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111});
    if (lane_mask != 4'b0000) begin
      assert_unused_lanes_zero_R4: assert ((lane_data & ~lane_bits) == '0);
    end
  end
endmodule

// File: tb/test_store_lane_aligner.sv
module test_store_lane_aligner;
  logic clk;
  logic rst_n;
  logic [31:0] store_instr, eff_addr, src_value;
  logic        mem_wr_en;
  logic [31:0] lane_data;
  logic [3:0]  lane_mask;
  logic        misaligned;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  store_lane_aligner i_store_lane_aligner (
    .store_instr (store_instr),
    .eff_addr    (eff_addr),
    .src_value   (src_value),
    .mem_wr_en   (mem_wr_en),
    .lane_data   (lane_data),
    .lane_mask   (lane_mask),
    .misaligned  (misaligned)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk_instr(logic [6:0] opc, logic [2:0] f3, logic [31:0] fill);
    logic [31:0] r;
    r = fill;
    r[6:0] = opc;
    r[14:12] = f3;
    return r;
  endfunction

  // reference table built from the requirements
  task automatic ref_model(input logic [31:0] ins, input logic [31:0] adr,
                           input logic [31:0] v, input logic we,
                           output logic [31:0] d, output logic [3:0] m,
                           output logic mis, output string tag);
    logic [1:0] o;
    logic st;
    logic good;
    o = adr[1:0];
    st = (ins[6:0] == 7'b0100011);
    d = 32'h0; m = 4'h0; good = 1'b0;
    case (ins[14:12])
      3'b000: begin
        good = 1'b1; tag = "R1";
        case (o)
          2'd0: begin d = {24'h0, v[7:0]};         m = 4'b0001; end
          2'd1: begin d = {16'h0, v[7:0], 8'h0};   m = 4'b0010; end
          2'd2: begin d = {8'h0, v[7:0], 16'h0};   m = 4'b0100; end
          default: begin d = {v[7:0], 24'h0};      m = 4'b1000; end
        endcase
      end
      3'b001: begin
        tag = "R2";
        case (o)
          2'd0: begin d = {16'h0, v[15:0]};        m = 4'b0011; good = 1'b1; end
          2'd1: begin d = {8'h0, v[15:0], 8'h0};   m = 4'b0000; end
          2'd2: begin d = {v[15:0], 16'h0};        m = 4'b1100; good = 1'b1; end
          default: begin d = {v[7:0], 24'h0};      m = 4'b0000; end
        endcase
        if (!good) tag = "R7";
      end
      3'b010: begin
        tag = "R3";
        case (o)
          2'd0: begin d = v; m = 4'b1111; good = 1'b1; end
          2'd1: d = {v[23:0], 8'h0};
          2'd2: d = {v[15:0], 16'h0};
          default: d = {v[7:0], 24'h0};
        endcase
        if (!good) tag = "R7";
      end
      default: tag = "R7";
    endcase
    mis = st && !good;
    if (!good || !we || !st) m = 4'h0;
    if (!st) tag = "R8";
    else if (!we) tag = "R5";
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] adr,
                       input logic [31:0] v, input logic we, input string force_tag);
    logic [31:0] d; logic [3:0] m; logic mis; string tag;
    @(negedge clk);
    store_instr = ins; eff_addr = adr; src_value = v; mem_wr_en = we;
    #1;
    ref_model(ins, adr, v, we, d, m, mis, tag);
    if (force_tag != "") tag = force_tag;
    check(tag, lane_data, d, "data");
    check(tag, {28'h0, lane_mask}, {28'h0, m}, "mask");
    check(tag, {31'h0, misaligned}, {31'h0, mis}, "misaligned");
  endtask

  localparam logic [6:0] ST = 7'b0100011;
  localparam logic [31:0] PAT = 32'hF1E2D3C4;

  initial begin
    store_instr = '0; eff_addr = '0; src_value = '0; mem_wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state with zero inputs: no write, no flag (R8)
    @(negedge clk); #1;
    check("R8", {28'h0, lane_mask}, 32'h0, "idle mask");
    check("R8", {31'h0, misaligned}, 32'h0, "idle flag");
    // every width at every offset, sign bits set in each byte
    for (int f = 0; f < 8; f++) begin
      for (int o = 0; o < 4; o++) begin
        apply(mk_instr(ST, 3'(f), 32'h0), 32'(o), PAT, 1'b1, "");
      end
    end
    // R4: sign bits must not spread
    apply(mk_instr(ST, 3'b000, 32'h0), 32'h1, 32'h0000_0080, 1'b1, "R4");
    apply(mk_instr(ST, 3'b001, 32'h0), 32'h0, 32'h1234_8001, 1'b1, "R4");
    // R5: enable low on legal stores
    apply(mk_instr(ST, 3'b010, 32'h0), 32'h0, PAT, 1'b0, "R5");
    apply(mk_instr(ST, 3'b001, 32'h0), 32'h2, PAT, 1'b0, "R5");
    // R7: flag independent of enable
    apply(mk_instr(ST, 3'b010, 32'h0), 32'h3, PAT, 1'b0, "R7");
    // R6: unused instruction bits set
    apply(mk_instr(ST, 3'b000, 32'hFFFF_8F80), 32'h2, PAT, 1'b1, "R6");
    apply(mk_instr(ST, 3'b010, 32'hA5A5_0F80), 32'h0, PAT, 1'b1, "R6");
    // R8: load opcode and others
    apply(mk_instr(7'b0000011, 3'b010, 32'h0), 32'h0, PAT, 1'b1, "R8");
    apply(mk_instr(7'b0100111, 3'b001, 32'h0), 32'h1, PAT, 1'b1, "R8");
    // R9: upper address bits
    apply(mk_instr(ST, 3'b001, 32'h0), 32'hFFFF_FFFE, PAT, 1'b1, "R9");
    apply(mk_instr(ST, 3'b000, 32'h0), 32'h8000_0005, PAT, 1'b1, "R9");
    // seeded random stream
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ins;
      logic [6:0] opc;
      opc = ($urandom % 4 != 0) ? ST : 7'($urandom);
      ins = mk_instr(opc, 3'($urandom % 4 == 0 ? $urandom : $urandom % 3), $urandom);
      apply(ins, $urandom, $urandom, 1'($urandom % 5 != 0), "");
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule